// File: doc/BRIEF.md
# Multi-Word Level Interrupt Aggregator

This block gathers level-sensitive interrupt sources, grouped in 32-bit words (one to four words), and folds them onto several parent interrupt outputs. Each source passes through a two-stage synchroniser. Software sees the synchronised level in a per-word status register and gates it with a per-word enable register. Every parent output has its own routing mask for each word. A parent is raised when at least one source is pending, enabled and routed to that parent.

A source bit that no parent routes is unused. It can never be enabled. For low-power operation, a separate wake-enable register per word is merged into the effective enable while the suspend input is high. A dedicated wake output reports any used, wake-enabled source that is active during suspend. Sources are level-type, so acknowledging an interrupt takes no hardware action: the source has to drop its line.

Registers sit behind a simple 32-bit bus. A write takes effect on the clock edge where it is presented. A read returns its data one cycle after the request.

Top module: `irqagg_top`

## Requirements
- R1: After reset, each word's enable register holds that word's 32-bit slice of the FWD_MASK parameter, and every wake-enable register is zero. Every routing mask is all ones, so a single-parent build forwards every source to its parent. All parent outputs and the wake output are low.
- R2: Word w occupies the byte addresses starting at 0x10*w. The enable register is at +0x0, the status register at +0x4 and the wake-enable register at +0x8. Read data appears on bus_rdata_o in the cycle after the read request.
- R3: Writing 1 to an enable bit unmasks that source, and writing 0 masks it.
- R4: Parent p's output is the registered OR, over all words, of status AND effective enable AND that parent's routing mask. A change on src_i reaches irq_o three clock edges later: two synchroniser stages and one output register.
- R5: A status bit follows the synchronised source level. Writing the status register changes neither status, enable nor wake-enable.
- R6: The routing mask of parent p for word w is at byte address 0x100 + 4*(p*WORDS + w), stored parent-major. Each mask is readable and writable.
- R7: A bit that is clear in every parent's routing mask for its word is unused. The enable and wake-enable bits of an unused source read as 0, ignore writes, and never contribute to any output.
- R8: While suspend_i is high and WAKE_CAP is set, the effective enable of each word is (enable OR wake-enable) restricted to used bits. When suspend_i falls, the stored enable alone applies again.
- R9: wake_o is registered. It is high one cycle after suspend_i is high together with any used source whose status and wake-enable bits are both set, and it is low whenever suspend_i was low in the previous cycle.
- R10: A read of an unimplemented location returns zero. Unimplemented locations are a word index of WORDS or more, word offset +0xC, a routing index of PARENTS*WORDS or more, and any address with bits [1:0] not zero. A write to any of these locations changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 32*WORDS | Level interrupt sources; bit 32*w+b is bit b of word w |
| suspend_i | input | 1 | Low-power mode request (synchronous) |
| bus_sel_i | input | 1 | Register access request |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 9 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | PARENTS | Parent interrupt outputs |
| wake_o | output | 1 | Wake request during suspend |

## Verification
The bench aims at a source bit that is removed from every routing mask. A design that kept the stored enable for such a bit would read back a 1 or raise a parent while the bit is unrouted. It also exercises a routing change on one parent only: a design that swapped the parent-major indexing would silence the wrong parent. The three-edge latency is sampled on both sides of the expected edge, which catches a missing or an extra pipeline stage. The suspend sequence enables a source through the wake-enable register alone, then releases suspend; a design that kept the merged enable would leave irq_o or wake_o high after the release. Writes to the status register and to unimplemented offsets are followed by read-back of the enable register, which exposes any aliasing decode.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int unsigned WORD_BITS = 32;
    localparam int unsigned MAX_WORDS = 4;
    localparam int unsigned ADDR_W    = 9;

    typedef logic [WORD_BITS-1:0] word_t;

    // Register offset inside a word window, taken from address bits [3:2]
    typedef enum logic [1:0] {
        OFS_ENABLE = 2'd0,
        OFS_STATUS = 2'd1,
        OFS_WAKE   = 2'd2,
        OFS_NONE   = 2'd3
    } word_ofs_e;
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stage1 = async_i;
        sync_d.stage2 = sync_q.stage1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign sync_o = sync_q.stage2;
endmodule

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int unsigned WORDS   = 2,
    parameter int unsigned PARENTS = 2,
    parameter logic [MAX_WORDS*WORD_BITS-1:0] FWD_MASK = '0
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         sel_i,
    input  logic                         wr_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  word_t                        wdata_i,
    input  logic [WORDS-1:0][WORD_BITS-1:0] status_i,
    output word_t                        rdata_o,
    output logic [WORDS-1:0][WORD_BITS-1:0] en_o,
    output logic [WORDS-1:0][WORD_BITS-1:0] wk_o,
    output logic [PARENTS*WORDS-1:0][WORD_BITS-1:0] rt_o,
    output logic [WORDS-1:0][WORD_BITS-1:0] used_o
);
    localparam int unsigned NROUTE = PARENTS * WORDS;

    typedef struct packed {
        logic [WORDS-1:0][WORD_BITS-1:0]  en;
        logic [WORDS-1:0][WORD_BITS-1:0]  wk;
        logic [NROUTE-1:0][WORD_BITS-1:0] rt;
        word_t                            rdata;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [WORDS-1:0][WORD_BITS-1:0] used;

    // Address decode
    logic       aligned, is_rt, rt_hit, w_hit, miss;
    logic [5:0] rt_idx;
    logic [3:0] word_idx;
    word_ofs_e  ofs;
    word_t      rd_val;

    assign aligned  = (addr_i[1:0] == 2'b00);
    assign is_rt    = addr_i[8];
    assign rt_idx   = addr_i[7:2];
    assign word_idx = addr_i[7:4];
    assign ofs      = word_ofs_e'(addr_i[3:2]);
    assign rt_hit   = aligned && is_rt && (int'(rt_idx) < int'(NROUTE));
    assign w_hit    = aligned && !is_rt && (int'(word_idx) < int'(WORDS));
    assign miss     = !rt_hit && !(w_hit && ofs != OFS_NONE);

    always_comb begin
        for (int w = 0; w < WORDS; w++) begin
            used[w] = '0;
            for (int p = 0; p < PARENTS; p++) begin
                used[w] = used[w] | regs_q.rt[p*WORDS + w];
            end
        end
    end

    always_comb begin
        regs_d = regs_q;
        rd_val = '0;
        for (int i = 0; i < NROUTE; i++) begin
            if (rt_hit && int'(rt_idx) == i) begin
                rd_val = regs_q.rt[i];
                if (sel_i && wr_i) regs_d.rt[i] = wdata_i;
            end
        end
        for (int w = 0; w < WORDS; w++) begin
            if (w_hit && int'(word_idx) == w) begin
                case (ofs)
                    OFS_ENABLE: begin
                        rd_val = regs_q.en[w] & used[w];
                        if (sel_i && wr_i) regs_d.en[w] = wdata_i & used[w];
                    end
                    OFS_STATUS: rd_val = status_i[w];
                    OFS_WAKE: begin
                        rd_val = regs_q.wk[w] & used[w];
                        if (sel_i && wr_i) regs_d.wk[w] = wdata_i & used[w];
                    end
                    default: rd_val = '0;
                endcase
            end
        end
        if (sel_i && !wr_i) regs_d.rdata = rd_val;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int w = 0; w < WORDS; w++) begin
                regs_q.en[w] <= FWD_MASK[w*WORD_BITS +: WORD_BITS];
            end
            regs_q.wk    <= '0;
            regs_q.rt    <= '1;
            regs_q.rdata <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata_o = regs_q.rdata;
    assign en_o    = regs_q.en;
    assign wk_o    = regs_q.wk;
    assign rt_o    = regs_q.rt;
    assign used_o  = used;

    // R10: unimplemented reads return zero
    p_unimpl_read_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && !wr_i && miss) |=> (rdata_o == '0));

    // R5: a status write leaves enable and wake-enable untouched
    p_status_write_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && wr_i && w_hit && ofs == OFS_STATUS) |=> ($stable(en_o) && $stable(wk_o)));

    for (genvar gw = 0; gw < WORDS; gw++) begin : g_chk
        // R7: an enable write never sets an unused bit
        p_en_write_masked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (sel_i && wr_i && w_hit && int'(word_idx) == gw && ofs == OFS_ENABLE)
            |=> ((en_o[gw] & ~$past(used[gw])) == '0));
    end
endmodule

// File: rtl/irqagg_route.sv
module irqagg_route
    import irqagg_pkg::*;
#(
    parameter int unsigned WORDS    = 2,
    parameter int unsigned PARENTS  = 2,
    parameter int unsigned WAKE_CAP = 1
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         suspend_i,
    input  logic [WORDS-1:0][WORD_BITS-1:0] status_i,
    input  logic [WORDS-1:0][WORD_BITS-1:0] en_i,
    input  logic [WORDS-1:0][WORD_BITS-1:0] wk_i,
    input  logic [PARENTS*WORDS-1:0][WORD_BITS-1:0] rt_i,
    input  logic [WORDS-1:0][WORD_BITS-1:0] used_i,
    output logic [PARENTS-1:0]           irq_o,
    output logic                         wake_o
);
    localparam bit HAS_WAKE = (WAKE_CAP != 0);

    typedef struct packed {
        logic [PARENTS-1:0] irq;
        logic               wake;
    } out_t;

    out_t out_d, out_q;
    logic [WORDS-1:0][WORD_BITS-1:0] eff_en;
    logic in_suspend;

    assign in_suspend = HAS_WAKE && suspend_i;

    always_comb begin
        for (int w = 0; w < WORDS; w++) begin
            eff_en[w] = (in_suspend ? (en_i[w] | wk_i[w]) : en_i[w]) & used_i[w];
        end
    end

    always_comb begin
        out_d = out_q;
        out_d.wake = 1'b0;
        for (int p = 0; p < PARENTS; p++) begin
            out_d.irq[p] = 1'b0;
            for (int w = 0; w < WORDS; w++) begin
                out_d.irq[p] = out_d.irq[p] |
                    (|(status_i[w] & eff_en[w] & rt_i[p*WORDS + w]));
            end
        end
        for (int w = 0; w < WORDS; w++) begin
            out_d.wake = out_d.wake | (in_suspend && (|(status_i[w] & wk_i[w] & used_i[w])));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign irq_o  = out_q.irq;
    assign wake_o = out_q.wake;

    // R9: wake only follows a cycle with suspend high
    p_wake_needs_suspend_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> $past(suspend_i));

    for (genvar gp = 0; gp < PARENTS; gp++) begin : g_chk
        // R4: a raised parent needs some active status in the prior cycle
        p_irq_needs_status_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_o[gp] |-> $past(|status_i));
    end
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int unsigned WORDS    = 2,
    parameter int unsigned PARENTS  = 2,
    parameter int unsigned WAKE_CAP = 1,
    parameter logic [MAX_WORDS*WORD_BITS-1:0] FWD_MASK = 128'h0000_0000_0000_0000_0000_0000_FFFF_FFFF
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [WORDS*WORD_BITS-1:0] src_i,
    input  logic                      suspend_i,
    input  logic                      bus_sel_i,
    input  logic                      bus_wr_i,
    input  logic [ADDR_W-1:0]         bus_addr_i,
    input  logic [WORD_BITS-1:0]      bus_wdata_i,
    output logic [WORD_BITS-1:0]      bus_rdata_o,
    output logic [PARENTS-1:0]        irq_o,
    output logic                      wake_o
);
    localparam int unsigned SRC_BITS = WORDS * WORD_BITS;

    logic [SRC_BITS-1:0]                     src_sync;
    logic [WORDS-1:0][WORD_BITS-1:0]         status;
    logic [WORDS-1:0][WORD_BITS-1:0]         en, wk, used;
    logic [PARENTS*WORDS-1:0][WORD_BITS-1:0] rt;

    irqagg_sync #(.WIDTH(SRC_BITS)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (src_i),
        .sync_o  (src_sync)
    );

    assign status = src_sync;

    irqagg_regs #(
        .WORDS    (WORDS),
        .PARENTS  (PARENTS),
        .FWD_MASK (FWD_MASK)
    ) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sel_i    (bus_sel_i),
        .wr_i     (bus_wr_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .status_i (status),
        .rdata_o  (bus_rdata_o),
        .en_o     (en),
        .wk_o     (wk),
        .rt_o     (rt),
        .used_o   (used)
    );

    irqagg_route #(
        .WORDS    (WORDS),
        .PARENTS  (PARENTS),
        .WAKE_CAP (WAKE_CAP)
    ) u_route (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .suspend_i (suspend_i),
        .status_i  (status),
        .en_i      (en),
        .wk_i      (wk),
        .rt_i      (rt),
        .used_i    (used),
        .irq_o     (irq_o),
        .wake_o    (wake_o)
    );
endmodule

// File: tb/irqagg_top_tb_top.sv
`timescale 1ns/1ps
module irqagg_top_tb_top;
    localparam int W = 3;
    localparam int P = 2;
    localparam logic [127:0] FWD = 128'h0000_0000_0000_0000_8000_0001_0000_00FF;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [W*32-1:0] src = '0;
    logic           susp = 1'b0;
    logic           sel = 1'b0, wr = 1'b0;
    logic [8:0]     addr = '0;
    logic [31:0]    wdata = '0;
    logic [31:0]    rdata;
    logic [P-1:0]   irq;
    logic           wake;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [31:0] en_m [W];
    logic [31:0] wk_m [W];
    logic [31:0] rt_m [P*W];

    always #4 clk = ~clk;

    irqagg_top #(.WORDS(W), .PARENTS(P), .WAKE_CAP(1), .FWD_MASK(FWD)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .suspend_i(susp),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
    );

    function automatic logic [31:0] m_used(int w);
        logic [31:0] u = '0;
        for (int p = 0; p < P; p++) u |= rt_m[p*W + w];
        return u;
    endfunction

    function automatic logic [P-1:0] exp_irq();
        logic [P-1:0] r = '0;
        for (int p = 0; p < P; p++) begin
            for (int w = 0; w < W; w++) begin
                logic [31:0] eff = (susp ? (en_m[w] | wk_m[w]) : en_m[w]) & m_used(w);
                r[p] = r[p] | (|(src[w*32 +: 32] & eff & rt_m[p*W + w]));
            end
        end
        return r;
    endfunction

    function automatic logic exp_wake();
        logic r = 1'b0;
        for (int w = 0; w < W; w++) r = r | (susp && (|(src[w*32 +: 32] & wk_m[w] & m_used(w))));
        return r;
    endfunction

    function automatic logic [31:0] exp_read(logic [8:0] a);
        int w, i;
        if (a[1:0] != 2'b00) return '0;
        if (a[8]) begin
            i = int'(a[7:2]);
            return (i < P*W) ? rt_m[i] : '0;
        end
        w = int'(a[7:4]);
        if (w >= W) return '0;
        case (a[3:2])
            2'd0: return en_m[w] & m_used(w);
            2'd1: return src[w*32 +: 32];
            2'd2: return wk_m[w] & m_used(w);
            default: return '0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [8:0] a, logic [31:0] d);
        int w, i;
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        if (a[1:0] == 2'b00) begin
            if (a[8]) begin
                i = int'(a[7:2]);
                if (i < P*W) rt_m[i] = d;
            end else begin
                w = int'(a[7:4]);
                if (w < W) begin
                    if (a[3:2] == 2'd0) en_m[w] = d & m_used(w);
                    if (a[3:2] == 2'd2) wk_m[w] = d & m_used(w);
                end
            end
        end
    endtask

    task automatic bus_check(logic [8:0] a, string req);
        logic [31:0] e;
        e = exp_read(a);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
        check(req, rdata, e);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic check_outs(string req);
        check(req, 32'(irq), 32'(exp_irq()));
        check(req, 32'(wake), 32'(exp_wake()));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        for (int w = 0; w < W; w++) begin
            en_m[w] = FWD[w*32 +: 32];
            wk_m[w] = '0;
        end
        for (int i = 0; i < P*W; i++) rt_m[i] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 wake", 32'(wake), 32'h0);
        bus_check(9'h000, "R1 R2 enable w0");
        bus_check(9'h010, "R1 R2 enable w1");
        bus_check(9'h028, "R1 R2 wake-enable w2");
        bus_check(9'h114, "R1 R6 route p1w2");

        // R4 latency: three edges from source to parent
        @(negedge clk);
        src[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R4 before third edge", 32'(irq), 32'h0);
        @(negedge clk);
        check("R4 third edge", 32'(irq), 32'h3);
        bus_check(9'h004, "R5 status w0");
        src[0] = 1'b0;
        settle();
        check_outs("R4 drop");

        // R6 parent-major routing: remove bit0 from parent1 word0 only
        bus_write(9'h10C, ~32'h1);
        src[0] = 1'b1;
        settle();
        check_outs("R6 parent1 masked");
        check("R6 irq value", 32'(irq), 32'h1);
        src[0] = 1'b0;
        bus_write(9'h10C, '1);

        // R3 mask / unmask
        bus_write(9'h000, 32'h0);
        src[1] = 1'b1;
        settle();
        check("R3 masked", 32'(irq), 32'h0);
        bus_write(9'h000, 32'h2);
        settle();
        check("R3 unmasked", 32'(irq), 32'h3);
        src[1] = 1'b0;

        // R7 unused bit
        bus_write(9'h100, ~32'h20);
        bus_write(9'h10C, ~32'h20);
        bus_write(9'h000, '1);
        bus_check(9'h000, "R7 enable reads 0 on unused");
        bus_write(9'h008, 32'h20);
        bus_check(9'h008, "R7 wake-enable unused");
        src[5] = 1'b1;
        settle();
        check("R7 unused no irq", 32'(irq), 32'h0);
        check_outs("R7 outputs");
        src[5] = 1'b0;
        bus_write(9'h100, '1);
        bus_write(9'h10C, '1);
        bus_check(9'h000, "R7 write was dropped");

        // R5 status write ignored
        bus_write(9'h004, 32'h0);
        bus_check(9'h000, "R5 enable unchanged");
        src[2] = 1'b1;
        settle();
        bus_check(9'h004, "R5 status follows source");
        src[2] = 1'b0;

        // R10 unimplemented locations
        bus_check(9'h030, "R10 word beyond WORDS");
        bus_check(9'h00C, "R10 offset 0xC");
        bus_check(9'h118, "R10 route beyond range");
        bus_check(9'h002, "R10 unaligned");
        bus_write(9'h00C, 32'h0);
        bus_write(9'h001, 32'h0);
        bus_check(9'h000, "R10 write ignored");

        // R8 R9 suspend path
        bus_write(9'h010, 32'h0);
        bus_write(9'h018, 32'h10);
        src[36] = 1'b1;
        settle();
        check("R8 awake no irq", 32'(irq), 32'h0);
        check("R9 awake no wake", 32'(wake), 32'h0);
        susp = 1'b1;
        settle();
        check("R8 suspend irq", 32'(irq), 32'h3);
        check("R9 suspend wake", 32'(wake), 32'h1);
        susp = 1'b0;
        settle();
        check("R8 release", 32'(irq), 32'h0);
        check("R9 release", 32'(wake), 32'h0);
        src[36] = 1'b0;
        settle();

        // Random phase
        for (int it = 0; it < 80; it++) begin
            int kind;
            logic [8:0] a;
            kind = int'($urandom % 6);
            case (kind)
                0: bus_write(9'(16 * ($urandom % W)), $urandom);
                1: bus_write(9'(16 * ($urandom % W) + 8), $urandom & $urandom);
                2: bus_write(9'(9'h100 + 4 * ($urandom % (P*W))), $urandom | $urandom | $urandom);
                3: src = {$urandom & $urandom, $urandom & $urandom, $urandom & $urandom};
                4: susp = 1'($urandom);
                default: src = '0;
            endcase
            settle();
            check_outs("R4 R8 R9 random outputs");
            a = 9'($urandom);
            a[1:0] = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
            bus_check(a, "R2 R6 R10 random read");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule